// File: doc/BRIEF.md
# Interrupt Sampling and Vector Selector

This block is the interrupt front end of an 8-bit processor core. It watches the level-sensitive maskable interrupt line and the edge-triggered non-maskable line. It remembers a pending start-up request from reset and tells the sequencer which source, if any, wants service. When the sequencer picks a vector, the block sends out the two byte addresses from which the new program counter is fetched. It also supplies the status byte to be stacked and tells the core when to raise its interrupt-disable flag.

The maskable line is sampled only on bus cycles, and it takes effect one bus cycle late. On each bus-cycle strobe, the pending bit takes the value held in a history register. The history register then takes "line asserted and disable flag clear". A falling edge on the non-maskable input stays latched until a vector pick consumes it. A software break that picks its vector while a non-maskable request is pending is taken over by that request.

The vector output is a valid/ready stream of two beats: the low-byte address, then the high-byte address. Each beat is held stable while `vec_ready` is low. A new pick is accepted only when the stream is empty, or in the cycle its final beat is taken.

Top module: `intv_front`

## Requirements
- R1: During and right after reset, `svc_req` is 1 with `svc_src` = 0 (reset), `irq_pend` and `nmi_pend` are 0, `vec_valid` and `set_iflag` are 0, and `pick_ready` is 1.
- R2: `irq_pend` changes only on a clock edge where `bus_stb` is 1. It then takes the value captured at the previous strobe, which gives one bus cycle of latency.
- R3: At each strobe the captured value is 1 only if `irq_n` is 0 and `iflag` is 0. A request present while `iflag` is 1 never raises `irq_pend`.
- R4: A 1-to-0 transition of `nmi_n` between two consecutive clock edges sets `nmi_pend`. It stays set until a pick consumes it. A new edge in the same cycle as a consume leaves it set.
- R5: `svc_req` is the OR of the reset, non-maskable and maskable pending bits. `svc_src` gives the highest-priority one: reset (0) over non-maskable (1) over maskable (2).
- R6: A pick with `pick_src` 0 gives base vector 0xFFFC, source 1 gives 0xFFFA, and source 2 (maskable) or 3 (software break) gives 0xFFFE.
- R7: A break pick (source 3) made while `nmi_pend` is 1 uses 0xFFFA and clears `nmi_pend`. A pick with source 1 also clears `nmi_pend`.
- R8: After an accepted pick, the stream sends the base address with `vec_last` = 0, then base+1 with `vec_last` = 1.
- R9: `vec_status` is `status_in` as seen at the pick, with bit 4 (break) forced to 1 for source 3 and forced to 0 for the other sources.
- R10: While `vec_valid` is 1 and `vec_ready` is 0, the address, last flag and status stay unchanged. `pick_ready` is 1 only when the stream is empty, or when the final beat is being taken.
- R11: `set_iflag` is 1 for exactly the one cycle in which the first beat of a newly accepted pick appears.
- R12: A pick with source 0 clears the reset pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_stb | input | 1 | One pulse per bus cycle; samples the maskable line |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, edge |
| iflag | input | 1 | Interrupt-disable flag of the core |
| status_in | input | 8 | Current status byte of the core |
| pick_valid | input | 1 | Vector pick command |
| pick_src | input | 2 | Pick source: 0 reset, 1 non-maskable, 2 maskable, 3 break |
| pick_ready | output | 1 | Pick can be accepted this cycle |
| svc_req | output | 1 | Some source requests service |
| svc_src | output | 2 | Highest-priority requesting source |
| irq_pend | output | 1 | Maskable request recognised |
| nmi_pend | output | 1 | Non-maskable edge latched |
| vec_valid | output | 1 | Vector beat available |
| vec_ready | input | 1 | Consumer takes the beat |
| vec_addr | output | 16 | Byte address of the PC byte to fetch |
| vec_last | output | 1 | Beat is the high-byte address |
| vec_status | output | 8 | Status byte to stack for this pick |
| set_iflag | output | 1 | Raise the interrupt-disable flag now |

## Verification
The assertions assume that `nmi_n` and `irq_n` are already synchronous to `clk`. They also assume that `vec_ready` may be dropped at any time, so the stability and beat-order properties cover any back-pressure pattern. The stimulus drives every input only at the falling edge. It mixes strobe gaps, masked and unmasked periods, rare non-maskable edges, and random picks of all four sources. The reference model assumes nothing about how often picks arrive, and it can issue a pick in the same cycle as a final beat.

// File: rtl/intv_pkg.sv
package intv_pkg;
  typedef enum logic [1:0] {
    SRC_RST = 2'd0,
    SRC_NMI = 2'd1,
    SRC_IRQ = 2'd2,
    SRC_BRK = 2'd3
  } src_e;

  localparam int STAT_W    = 8;
  localparam int BREAK_POS = 4;
endpackage

// File: rtl/intv_irq_sample.sv
module intv_irq_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_stb,
  input  logic irq_n,
  input  logic iflag,
  output logic irq_pend
);
  logic hist_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (bus_stb) begin
      pend_q <= hist_q;
      hist_q <= ~irq_n & ~iflag;
    end
  end

  assign irq_pend = pend_q;
endmodule

// File: rtl/intv_nmi_latch.sv
module intv_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic consume,
  output logic nmi_pend
);
  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall = prev_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      if (fall)         pend_q <= 1'b1;
      else if (consume) pend_q <= 1'b0;
    end
  end

  assign nmi_pend = pend_q;
endmodule

// File: rtl/intv_vec_pick.sv
module intv_vec_pick
  import intv_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  logic [1:0]        src,
  input  logic              rst_pend,
  input  logic              nmi_pend,
  input  logic              irq_pend,
  input  logic [STAT_W-1:0] status_in,
  output logic [AW-1:0]     base,
  output logic [STAT_W-1:0] status_out,
  output logic              eat_nmi,
  output logic              eat_rst,
  output logic              svc_req,
  output logic [1:0]        svc_src
);
  src_e s;
  assign s = src_e'(src);

  always_comb begin
    base    = AW'(VEC_IRQ);
    eat_nmi = 1'b0;
    eat_rst = 1'b0;
    unique case (s)
      SRC_RST: begin base = AW'(VEC_RST); eat_rst = 1'b1; end
      SRC_NMI: begin base = AW'(VEC_NMI); eat_nmi = 1'b1; end
      SRC_IRQ: base = AW'(VEC_IRQ);
      SRC_BRK: begin
        if (nmi_pend) begin
          base    = AW'(VEC_NMI);
          eat_nmi = 1'b1;
        end else begin
          base = AW'(VEC_IRQ);
        end
      end
      default: base = AW'(VEC_IRQ);
    endcase
  end

  always_comb begin
    status_out            = status_in;
    status_out[BREAK_POS] = (s == SRC_BRK);
  end

  always_comb begin
    svc_req = rst_pend | nmi_pend | irq_pend;
    if (rst_pend)      svc_src = SRC_RST;
    else if (nmi_pend) svc_src = SRC_NMI;
    else               svc_src = SRC_IRQ;
  end
endmodule

// File: rtl/intv_vec_stream.sv
module intv_vec_stream
  import intv_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [AW-1:0]     base_in,
  input  logic [STAT_W-1:0] stat_in,
  output logic              can_load,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [AW-1:0]     vec_addr,
  output logic              vec_last,
  output logic [STAT_W-1:0] vec_status,
  output logic              set_iflag
);
  logic              vld_q, beat_q, seti_q;
  logic [AW-1:0]     base_q;
  logic [STAT_W-1:0] stat_q;
  logic              take, load;

  assign take     = vld_q & vec_ready;
  assign can_load = ~vld_q | (take & beat_q);
  assign load     = load_req & can_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      beat_q <= 1'b0;
      seti_q <= 1'b0;
      base_q <= '0;
      stat_q <= '0;
    end else begin
      seti_q <= load;
      if (load) begin
        vld_q  <= 1'b1;
        beat_q <= 1'b0;
        base_q <= base_in;
        stat_q <= stat_in;
      end else if (take) begin
        if (beat_q) vld_q  <= 1'b0;
        else        beat_q <= 1'b1;
      end
    end
  end

  assign vec_valid  = vld_q;
  assign vec_addr   = base_q + AW'(beat_q);
  assign vec_last   = beat_q;
  assign vec_status = stat_q;
  assign set_iflag  = seti_q;
endmodule

// File: rtl/intv_front.sv
module intv_front
  import intv_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              iflag,
  input  logic [STAT_W-1:0] status_in,
  input  logic              pick_valid,
  input  logic [1:0]        pick_src,
  output logic              pick_ready,
  output logic              svc_req,
  output logic [1:0]        svc_src,
  output logic              irq_pend,
  output logic              nmi_pend,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [AW-1:0]     vec_addr,
  output logic              vec_last,
  output logic [STAT_W-1:0] vec_status,
  output logic              set_iflag
);
  logic              rst_pend_q;
  logic              can_load, pick_acc;
  logic              eat_nmi, eat_rst;
  logic [AW-1:0]     base;
  logic [STAT_W-1:0] stat_sel;

  assign pick_acc   = pick_valid & can_load;
  assign pick_ready = can_load;

  always_ff @(posedge clk) begin
    if (!rst_n)                  rst_pend_q <= 1'b1;
    else if (pick_acc & eat_rst) rst_pend_q <= 1'b0;
  end

  intv_irq_sample u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_stb  (bus_stb),
    .irq_n    (irq_n),
    .iflag    (iflag),
    .irq_pend (irq_pend)
  );

  intv_nmi_latch u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_n    (nmi_n),
    .consume  (pick_acc & eat_nmi),
    .nmi_pend (nmi_pend)
  );

  intv_vec_pick #(
    .AW(AW), .VEC_NMI(VEC_NMI), .VEC_RST(VEC_RST), .VEC_IRQ(VEC_IRQ)
  ) u_pick (
    .src        (pick_src),
    .rst_pend   (rst_pend_q),
    .nmi_pend   (nmi_pend),
    .irq_pend   (irq_pend),
    .status_in  (status_in),
    .base       (base),
    .status_out (stat_sel),
    .eat_nmi    (eat_nmi),
    .eat_rst    (eat_rst),
    .svc_req    (svc_req),
    .svc_src    (svc_src)
  );

  intv_vec_stream #(.AW(AW)) u_str (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_req   (pick_valid),
    .base_in    (base),
    .stat_in    (stat_sel),
    .can_load   (can_load),
    .vec_valid  (vec_valid),
    .vec_ready  (vec_ready),
    .vec_addr   (vec_addr),
    .vec_last   (vec_last),
    .vec_status (vec_status),
    .set_iflag  (set_iflag)
  );
endmodule

// File: rtl/intv_front_chk.sv
module intv_front_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_stb,
  input logic          nmi_n,
  input logic          irq_pend,
  input logic          nmi_pend,
  input logic          svc_req,
  input logic [1:0]    svc_src,
  input logic          vec_valid,
  input logic          vec_ready,
  input logic [AW-1:0] vec_addr,
  input logic          vec_last,
  input logic [7:0]    vec_status,
  input logic          set_iflag
);
  // R2
  irq_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(irq_pend) |-> $past(bus_stb));

  // R4
  nmi_edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_n) |=> nmi_pend);

  // R5
  irq_src_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && svc_src == 2'd2) |-> (irq_pend && !nmi_pend));

  // R8
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready && !vec_last) |=>
      (vec_valid && vec_last && vec_addr == $past(vec_addr) + AW'(1)));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=>
      (vec_valid && $stable(vec_addr) && $stable(vec_last) && $stable(vec_status)));

  // R11
  seti_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_iflag |-> (vec_valid && !vec_last));
endmodule

bind intv_front intv_front_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_stb    (bus_stb),
  .nmi_n      (nmi_n),
  .irq_pend   (irq_pend),
  .nmi_pend   (nmi_pend),
  .svc_req    (svc_req),
  .svc_src    (svc_src),
  .vec_valid  (vec_valid),
  .vec_ready  (vec_ready),
  .vec_addr   (vec_addr),
  .vec_last   (vec_last),
  .vec_status (vec_status),
  .set_iflag  (set_iflag)
);

// File: tb/tb_intv_front.sv
`timescale 1ns/1ps
module tb_intv_front;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_stb = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, iflag = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic pick_valid = 1'b0;
  logic [1:0] pick_src = 2'd0;
  logic vec_ready = 1'b0;
  logic pick_ready, svc_req, irq_pend, nmi_pend, vec_valid, vec_last, set_iflag;
  logic [1:0] svc_src;
  logic [15:0] vec_addr;
  logic [7:0] vec_status;

  always #2 clk = ~clk;

  intv_front dut (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .irq_n(irq_n), .nmi_n(nmi_n),
    .iflag(iflag), .status_in(status_in), .pick_valid(pick_valid), .pick_src(pick_src),
    .pick_ready(pick_ready), .svc_req(svc_req), .svc_src(svc_src), .irq_pend(irq_pend),
    .nmi_pend(nmi_pend), .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
    .vec_last(vec_last), .vec_status(vec_status), .set_iflag(set_iflag)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_rst, m_nmi, m_prev, m_hist, m_irq, m_vld, m_beat, m_seti;
  int m_base, m_stat;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_rdy();
    return (!m_vld || (vec_ready && m_beat == 1)) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rst = 1; m_nmi = 0; m_prev = 1; m_hist = 0; m_irq = 0;
      m_vld = 0; m_beat = 0; m_seti = 0; m_base = 0; m_stat = 0;
    end else begin
      int acc, take, fall, eat_n, n_nmi;
      acc  = (pick_valid && exp_rdy()) ? 1 : 0;
      take = (m_vld && vec_ready) ? 1 : 0;
      fall = (m_prev && !nmi_n) ? 1 : 0;
      eat_n = 0;
      if (acc) begin
        case (pick_src)
          2'd0: begin m_base = 'hFFFC; m_rst = 0; end
          2'd1: begin m_base = 'hFFFA; eat_n = 1; end
          2'd2: m_base = 'hFFFE;
          default: begin
            if (m_nmi) begin m_base = 'hFFFA; eat_n = 1; end
            else m_base = 'hFFFE;
          end
        endcase
        m_stat = (pick_src == 2'd3) ? (status_in | 8'h10) : (status_in & 8'hEF);
        m_vld = 1; m_beat = 0;
      end else if (take) begin
        if (m_beat == 1) m_vld = 0; else m_beat = 1;
      end
      m_seti = acc;
      n_nmi = fall ? 1 : (eat_n ? 0 : m_nmi);
      m_nmi = n_nmi;
      m_prev = nmi_n;
      if (bus_stb) begin
        m_irq = m_hist;
        m_hist = (!irq_n && !iflag) ? 1 : 0;
      end
    end
  end

  // per-cycle comparison, 1 ns after inputs move at the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int esrc, ereq;
      ereq = (m_rst || m_nmi || m_irq) ? 1 : 0;
      esrc = m_rst ? 0 : (m_nmi ? 1 : 2);
      chk(irq_pend == m_irq[0], "R2/R3 irq_pend", irq_pend, m_irq);
      chk(nmi_pend == m_nmi[0], "R4 nmi_pend", nmi_pend, m_nmi);
      chk(svc_req == ereq[0], "R5 svc_req", svc_req, ereq);
      if (ereq) chk(svc_src == esrc[1:0], "R5 svc_src", svc_src, esrc);
      chk(pick_ready == exp_rdy()[0], "R10 pick_ready", pick_ready, exp_rdy());
      chk(vec_valid == m_vld[0], "R10 vec_valid", vec_valid, m_vld);
      chk(set_iflag == m_seti[0], "R11 set_iflag", set_iflag, m_seti);
      if (m_vld) begin
        if (m_beat == 0) chk(vec_addr == m_base[15:0], "R6 vec_addr beat0", vec_addr, m_base);
        else chk(vec_addr == 16'(m_base + 1), "R8 vec_addr beat1", vec_addr, m_base + 1);
        chk(vec_last == m_beat[0], "R8 vec_last", vec_last, m_beat);
        chk(vec_status == m_stat[7:0], "R9 vec_status", vec_status, m_stat);
      end
    end
  end

  task automatic step(input bit stb, input bit irq, input bit nmi, input bit ifl,
                      input bit pv, input logic [1:0] ps, input bit rdy, input logic [7:0] st);
    @(negedge clk);
    bus_stb = stb; irq_n = irq; nmi_n = nmi; iflag = ifl;
    pick_valid = pv; pick_src = ps; vec_ready = rdy; status_in = st;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 1, 1, 0, 0, 2'd0, 1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(svc_req == 1'b1 && svc_src == 2'd0, "R1 svc during reset", {svc_req, svc_src}, 3'b100);
    chk(!irq_pend && !nmi_pend && !vec_valid && !set_iflag && pick_ready,
        "R1 idle outputs", {irq_pend, nmi_pend, vec_valid, set_iflag, pick_ready}, 5'b00001);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    // R12 reset pick clears reset pending; status break bit forced low (R9)
    step(0, 1, 1, 0, 1, 2'd0, 0, 8'hFF);
    step(0, 1, 1, 0, 0, 2'd0, 0, 8'h00);
    #1;
    chk(vec_addr == 16'hFFFC && vec_status == 8'hEF, "R6/R9 reset pick", vec_addr, 16'hFFFC);
    chk(svc_req == 1'b0, "R12 reset pending cleared", svc_req, 0);
    idle(3);
    // R3 masked request: strobes with iflag high never raise irq_pend
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 0, 2'd0, 1, 8'h00);
    step(0, 0, 1, 1, 0, 2'd0, 1, 8'h00);
    #1 chk(irq_pend == 1'b0, "R3 masked irq", irq_pend, 0);
    // R2 latency: two strobes needed
    step(1, 0, 1, 0, 0, 2'd0, 1, 8'h00);
    step(0, 0, 1, 0, 0, 2'd0, 1, 8'h00);
    #1 chk(irq_pend == 1'b0, "R2 one strobe not enough", irq_pend, 0);
    step(1, 0, 1, 0, 0, 2'd0, 1, 8'h00);
    step(0, 1, 1, 0, 0, 2'd0, 1, 8'h00);
    #1 chk(irq_pend == 1'b1, "R2 second strobe", irq_pend, 1);
    idle(2);
    step(1, 1, 1, 0, 0, 2'd0, 1, 8'h00);
    step(1, 1, 1, 0, 0, 2'd0, 1, 8'h00);
    // R4/R7 NMI edge then break hijack
    step(0, 1, 0, 0, 0, 2'd0, 1, 8'h00);
    idle(3);
    #1 chk(nmi_pend == 1'b1, "R4 nmi held", nmi_pend, 1);
    step(0, 1, 1, 0, 1, 2'd3, 0, 8'h20);
    step(0, 1, 1, 0, 0, 2'd0, 0, 8'h00);
    #1;
    chk(vec_addr == 16'hFFFA, "R7 break hijacked", vec_addr, 16'hFFFA);
    chk(vec_status == 8'h30, "R9 break bit set", vec_status, 8'h30);
    chk(nmi_pend == 1'b0, "R7 nmi consumed", nmi_pend, 0);
    // R10 back-pressure hold then pick in final-beat cycle
    idle(1);
    step(0, 1, 1, 0, 0, 2'd0, 0, 8'h00);
    step(0, 1, 1, 0, 1, 2'd2, 1, 8'h04);
    step(0, 1, 1, 0, 0, 2'd0, 0, 8'h00);
    #1 chk(vec_addr == 16'hFFFE && set_iflag, "R11 back-to-back pick", vec_addr, 16'hFFFE);
    idle(4);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1] | r[2], (r[9:3] != 0) ? 1'b1 : 1'b0, r[10] & r[11],
           r[12] & r[13], r[15:14], r[16] | r[17], r[25:18]);
    end
    idle(4);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule